// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block gathers up to 32 interrupt lines into one request line for a processor. Each input is sensed either on its rising edge or by its level. The kind of each input is fixed by a parameter mask. A detected request is held in a status bit until software clears it through a write-one-to-clear acknowledge register. A per-input enable mask turns the status into the pending set.

A vector register gives the index of the pending source with the lowest number, which is the highest priority. It reads all ones when nothing is pending. The request output is raised only when two things hold: there is a pending bit, and both bits of the master control register are on. Bit 0 is the run bit. Bit 1 is the hardware-output bit, and once it is set it stays set until reset.

Software reaches the block through a plain 32-bit register port: a byte address, a write strobe, write data, and read data that is combinational from the address. A typical bring-up clears the enables, acknowledges everything, writes 0x3 to the master register and reads it back to confirm the controller is live.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, status, pending, enable and master registers read 0, the vector register reads 0xFFFFFFFF and irq_o is low.
- R2: A write to the set-enable alias (offset 0x10) sets each enable bit written as 1. A write to the clear-enable alias (offset 0x14) clears each enable bit written as 1. Bits written as 0 leave their enables unchanged.
- R3: A write to the enable register (offset 0x08) replaces all enable bits; writing 0 disables every input.
- R4: A level-kind input (kind mask bit 0) sets its status bit (offset 0x00) on every clock edge at which it is high, so an acknowledge while it stays high leaves the bit set. The bit stays latched after the input drops.
- R5: An edge-kind input (kind mask bit 1) sets its status bit only on a low-to-high change seen at a clock edge. Holding it high after an acknowledge does not set it again.
- R6: Writing 1s to the acknowledge register (offset 0x0C) clears the matching status bits, 0 bits leave them, and writing 0xFFFFFFFF clears every status bit.
- R7: The pending register (offset 0x04) reads status AND enable.
- R8: The vector register (offset 0x18) reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when no bit is pending.
- R9: The master register (offset 0x1C) reads back bit 0 (run) and bit 1 (hardware output). irq_o is high exactly when both bits are 1 and at least one bit is pending.
- R10: Once the hardware-output bit is 1, later writes cannot clear it; only reset does. The run bit follows each write.
- R11: Data bits at or above the input count are ignored by the status and enable registers and read as 0. The acknowledge and both enable aliases read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source lines |
| reg_addr | input | 5 | Byte address of the register, word aligned |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the write strobe is sampled only at rising clock edges and that address and data are stable around that edge. They also assume that the source lines are synchronous to the clock, since a level-kind input is expected to appear in status one edge after it is seen high. The bench meets these assumptions by changing every input on the falling edge and holding each write for exactly one cycle. It sweeps the full enable space and the full status space of an eight-input configuration, with four level inputs and four edge inputs.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int MAX_SRC    = 32;
  localparam int DATA_W     = 32;
  localparam int REG_ADDR_W = 5;
  localparam int SEL_W      = 3;

  // word index of each register inside the 8-word window
  typedef enum logic [SEL_W-1:0] {
    RG_STAT  = 3'd0,
    RG_PEND  = 3'd1,
    RG_ENAB  = 3'd2,
    RG_ACK   = 3'd3,
    RG_SETEN = 3'd4,
    RG_CLREN = 3'd5,
    RG_VEC   = 3'd6,
    RG_MAST  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irqc_sense.sv
module irqc_sense #(
  parameter int          NUM_SRC   = 32,
  parameter logic [31:0] EDGE_KIND = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] hit_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    if (EDGE_KIND[g]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i[g];
      end
      assign hit_o[g] = src_i[g] & ~prev_q;
    end else begin : g_lvl
      assign hit_o[g] = src_i[g];
    end
  end
endmodule

// File: rtl/irqc_core.sv
module irqc_core #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hit_i,
  input  logic               we_ack,
  input  logic               we_en,
  input  logic               we_set,
  input  logic               we_clr,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] enable_o
);
  logic [NUM_SRC-1:0] stat_q, stat_d;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic               en_ce;

  // new hits win over an acknowledge landing in the same cycle
  always_comb begin
    stat_d = stat_q;
    if (we_ack) stat_d = stat_d & ~wdata_i;
    stat_d = stat_d | hit_i;
  end

  always_comb begin
    en_d = en_q;
    if (we_en)  en_d = wdata_i;
    if (we_set) en_d = en_q | wdata_i;
    if (we_clr) en_d = en_q & ~wdata_i;
  end
  assign en_ce = we_en | we_set | we_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign status_o = stat_q;
  assign enable_o = en_q;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NUM_SRC = 32,
  parameter int OUT_W   = 32
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [OUT_W-1:0]   vec_o,
  output logic               any_o
);
  // scan downward so the lowest set index is the last one kept
  always_comb begin
    vec_o = '1;
    any_o = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        vec_o = OUT_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int          NUM_SRC   = 32,
  parameter logic [31:0] EDGE_KIND = 32'h0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_we,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  irq_o
);
  localparam int SEL_LSB = 2;

  reg_sel_e           sel;
  logic [NUM_SRC-1:0] hit_w, status_q, enable_q, pend_w;
  logic [DATA_W-1:0]  vec_w, stat_ext, en_ext, pend_ext;
  logic               any_w;
  logic               me_q, me_d, hie_q, hie_d;
  logic               we_mast;
  logic [1:0]         unused_addr;

  assign sel         = reg_sel_e'(reg_addr[SEL_LSB +: SEL_W]);
  assign unused_addr = reg_addr[SEL_LSB-1:0];
  assign we_mast     = reg_we && (sel == RG_MAST);

  irqc_sense #(.NUM_SRC(NUM_SRC), .EDGE_KIND(EDGE_KIND)) u_sense (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .hit_o (hit_w)
  );

  irqc_core #(.NUM_SRC(NUM_SRC)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit_w),
    .we_ack   (reg_we && (sel == RG_ACK)),
    .we_en    (reg_we && (sel == RG_ENAB)),
    .we_set   (reg_we && (sel == RG_SETEN)),
    .we_clr   (reg_we && (sel == RG_CLREN)),
    .wdata_i  (reg_wdata[NUM_SRC-1:0]),
    .status_o (status_q),
    .enable_o (enable_q)
  );

  assign pend_w = status_q & enable_q;

  irqc_prio #(.NUM_SRC(NUM_SRC), .OUT_W(DATA_W)) u_prio (
    .pend_i (pend_w),
    .vec_o  (vec_w),
    .any_o  (any_w)
  );

  // master control: run bit follows writes, output bit is sticky
  always_comb begin
    me_d  = me_q;
    hie_d = hie_q;
    if (we_mast) begin
      me_d  = reg_wdata[0];
      hie_d = hie_q | reg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      me_q  <= 1'b0;
      hie_q <= 1'b0;
    end else if (we_mast) begin
      me_q  <= me_d;
      hie_q <= hie_d;
    end
  end

  assign irq_o = me_q & hie_q & any_w;

  always_comb begin
    stat_ext = '0;
    en_ext   = '0;
    pend_ext = '0;
    stat_ext[NUM_SRC-1:0] = status_q;
    en_ext[NUM_SRC-1:0]   = enable_q;
    pend_ext[NUM_SRC-1:0] = pend_w;
  end

  always_comb begin
    unique case (sel)
      RG_STAT: reg_rdata = stat_ext;
      RG_PEND: reg_rdata = pend_ext;
      RG_ENAB: reg_rdata = en_ext;
      RG_VEC:  reg_rdata = vec_w;
      RG_MAST: reg_rdata = {{(DATA_W-2){1'b0}}, hie_q, me_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int          NUM_SRC   = 32,
  parameter logic [31:0] EDGE_KIND = 32'h0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SEL_W-1:0]   sel_i,
  input logic               we_i,
  input logic [NUM_SRC-1:0] wd_i,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] enable_q,
  input logic               me_q,
  input logic               hie_q,
  input logic [DATA_W-1:0]  vec_w,
  input logic               irq_o
);
  localparam logic [NUM_SRC-1:0] LVL_MASK = ~EDGE_KIND[NUM_SRC-1:0];

  // R2
  set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == RG_SETEN) |=> ((enable_q & $past(wd_i)) == $past(wd_i)));

  // R2
  clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == RG_CLREN) |=> ((enable_q & $past(wd_i)) == '0));

  // R4
  lvl_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_i & LVL_MASK) != '0) |=>
      ((status_q & $past(src_i & LVL_MASK)) == $past(src_i & LVL_MASK)));

  // R8
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & enable_q) == '0) |-> (vec_w == '1));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (me_q && hie_q && ((status_q & enable_q) != '0)));

  // R10
  hie_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hie_q |=> hie_q);
endmodule

bind vec_irq_ctrl irqc_chk #(.NUM_SRC(NUM_SRC), .EDGE_KIND(EDGE_KIND)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_i    (reg_addr[4:2]),
  .we_i     (reg_we),
  .wd_i     (reg_wdata[NUM_SRC-1:0]),
  .src_i    (src_i),
  .status_q (status_q),
  .enable_q (enable_q),
  .me_q     (me_q),
  .hie_q    (hie_q),
  .vec_w    (vec_w),
  .irq_o    (irq_o)
);

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_vec_irq_ctrl;
  localparam int          N    = 8;
  localparam logic [31:0] KIND = 32'hFFFF_FFF0; // bits 4..7 edge, 0..3 level

  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_ENAB = 5'h08,
                         A_ACK  = 5'h0C, A_SET  = 5'h10, A_CLR  = 5'h14,
                         A_VEC  = 5'h18, A_MAST = 5'h1C;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] src;
  logic [4:0]   addr;
  logic         we;
  logic [31:0]  wdata;
  logic [31:0]  rdata;
  logic         irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(N), .EDGE_KIND(KIND)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .reg_addr  (addr),
    .reg_we    (we),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .irq_o     (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] lowest(input logic [N-1:0] p);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = N - 1; i >= 0; i--) if (p[i]) r = i;
    return r;
  endfunction

  // load status with an exact pattern: clear, pulse sources one cycle, release
  task automatic load_status(input logic [N-1:0] s);
    src = '0;
    wr(A_ACK, 32'hFFFF_FFFF);
    src = s;
    step(1);
    src = '0;
    step(1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [N-1:0] acc;
    rst_n = 1'b0; src = '0; addr = '0; we = 1'b0; wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_PEND, v); chk("R1 pending", v, 0);
    rd(A_ENAB, v); chk("R1 enable", v, 0);
    rd(A_MAST, v); chk("R1 master", v, 0);
    rd(A_VEC,  v); chk("R1 vector", v, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq}, 0);

    // R11 write-only aliases read zero
    rd(A_ACK, v); chk("R11 ack reads 0", v, 0);
    rd(A_SET, v); chk("R11 set reads 0", v, 0);
    rd(A_CLR, v); chk("R11 clr reads 0", v, 0);

    // R2 set / clear aliases, one bit at a time
    acc = '0;
    for (int i = 0; i < N; i++) begin
      wr(A_SET, 32'(1) << i);
      acc[i] = 1'b1;
      rd(A_ENAB, v); chk("R2 set alias", v, 32'(acc));
    end
    wr(A_SET, 0); rd(A_ENAB, v); chk("R2 set zero no effect", v, 32'hFF);
    wr(A_CLR, 0); rd(A_ENAB, v); chk("R2 clr zero no effect", v, 32'hFF);
    for (int i = 0; i < N; i++) begin
      wr(A_CLR, 32'(1) << i);
      acc[i] = 1'b0;
      rd(A_ENAB, v); chk("R2 clr alias", v, 32'(acc));
    end

    // R3 direct enable write
    wr(A_ENAB, 32'hA5); rd(A_ENAB, v); chk("R3 direct", v, 32'hA5);
    wr(A_ENAB, 32'h0);  rd(A_ENAB, v); chk("R3 write zero", v, 0);

    // R11 upper data bits ignored by enable
    wr(A_SET, 32'hFFFF_FF00); rd(A_ENAB, v); chk("R11 upper enable", v, 0);

    // R4 level input
    src = 8'h01; step(1);
    rd(A_STAT, v); chk("R4 level set", v, 32'h01);
    wr(A_ACK, 32'h01); rd(A_STAT, v); chk("R4 level re-set after ack", v, 32'h01);
    src = 8'h00; step(1);
    rd(A_STAT, v); chk("R4 latched after drop", v, 32'h01);
    wr(A_ACK, 32'h01); rd(A_STAT, v); chk("R4 cleared", v, 0);

    // R5 edge input
    src = 8'h10; step(3);
    rd(A_STAT, v); chk("R5 edge set", v, 32'h10);
    wr(A_ACK, 32'h10); step(2);
    rd(A_STAT, v); chk("R5 held high no re-set", v, 0);
    src = 8'h00; step(1); src = 8'h10; step(1);
    rd(A_STAT, v); chk("R5 new edge", v, 32'h10);
    src = 8'h00; step(1);

    // R6 acknowledge
    load_status(8'hFF);
    rd(A_STAT, v); chk("R6 all set", v, 32'hFF);
    wr(A_ACK, 32'h05); rd(A_STAT, v); chk("R6 partial ack", v, 32'hFA);
    wr(A_ACK, 32'h00); rd(A_STAT, v); chk("R6 zero ack", v, 32'hFA);
    wr(A_ACK, 32'hFFFF_FFFF); rd(A_STAT, v); chk("R6 ack all", v, 0);

    // R9 gating before the output bit is on
    load_status(8'hFF);
    wr(A_ENAB, 32'hFF); wr(A_MAST, 32'h1);
    rd(A_MAST, v); chk("R9 master readback", v, 32'h1);
    chk("R9 irq needs output bit", {31'b0, irq}, 0);
    wr(A_MAST, 32'h3);
    rd(A_MAST, v); chk("R9 master both", v, 32'h3);

    // R7 R8 R9 exhaustive enable sweep with all status set
    for (int e = 0; e < 256; e++) begin
      wr(A_ENAB, 32'(e));
      rd(A_PEND, v); chk("R7 pending sweep", v, 32'(e));
      rd(A_VEC,  v); chk("R8 vector sweep", v, lowest(N'(e)));
      chk("R9 irq sweep", {31'b0, irq}, {31'b0, (e != 0)});
    end

    // R4 R5 R8 exhaustive status sweep with all enabled
    wr(A_ENAB, 32'hFF);
    for (int s = 0; s < 256; s++) begin
      load_status(N'(s));
      rd(A_STAT, v); chk("R4 R5 status sweep", v, 32'(s));
      rd(A_VEC,  v); chk("R8 vector status sweep", v, lowest(N'(s)));
    end

    // R10 sticky output bit, run bit follows writes
    load_status(8'h08);
    wr(A_MAST, 32'h2); rd(A_MAST, v); chk("R10 run off", v, 32'h2);
    chk("R9 irq run off", {31'b0, irq}, 0);
    wr(A_MAST, 32'h0); rd(A_MAST, v); chk("R10 output bit sticky", v, 32'h2);
    wr(A_MAST, 32'h1); rd(A_MAST, v); chk("R10 run back on", v, 32'h3);
    chk("R9 irq on", {31'b0, irq}, 1);
    wr(A_ACK, 32'h08);
    chk("R9 irq off when none pending", {31'b0, irq}, 0);
    rd(A_VEC, v); chk("R8 vector none pending", v, 32'hFFFF_FFFF);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule